// File: doc/BRIEF.md
# Paged Segmentation Address Translator

This block turns a two-part logical address into a physical address. The logical address is a segment number plus an offset inside that segment. The translation runs in two table lookups. The segment number selects a segment descriptor, which holds a valid flag, the segment length, read/write/execute permission flags and the base of that segment's page table. The upper bits of the offset then select an entry in that page table, and the entry supplies a frame number. The frame number, placed above the in-page offset, forms the physical address.

Both tables are held inside the block and are loaded through two write ports, one for the descriptors and one for the page entries. Requests use a valid/ready handshake. Each accepted request produces exactly one response a fixed two cycles later. The response carries either the physical address or one fault code, chosen by a fixed priority. A table write always wins over a request: while a write is applied, ready is held low.

Top module: `pst_translator`

## Requirements
- R1: While reset is held, and right after it is released, resp_valid is 0, req_ready is 1 once reset is low, and every descriptor and page entry is invalid, so the first translation after reset reports a segment fault.
- R2: The offset bits [15:10] form the page index and bits [9:0] form the in-page offset. A clean response returns resp_paddr = {frame, in-page offset}, which is frame × 1024 + in-page offset. Segment 15 with length 5096, offset 3921 and page 3 in frame 12 gives 13137.
- R3: A segment number at or above NUM_SEGS (default 16), or one whose descriptor is not valid, reports fault code 1 (segment).
- R4: An offset greater than or equal to the segment length reports fault code 2 (bounds). An offset of length−1 passes this check. A length of 65536 admits every offset.
- R5: Access code 0 (read) needs permission bit 0, code 1 (write) needs bit 1, and code 2 (execute) needs bit 2. Code 3 is always refused. A refused access reports fault code 3 (permission).
- R6: The page entry is read at (page-table base + page index) modulo PT_ENTRIES (default 256). An entry that is not valid reports fault code 4 (page).
- R7: Faults have a fixed priority: segment (1), then bounds (2), then permission (3), then page (4). Only the highest one is reported. Code 0 means success. resp_paddr is 0 whenever the fault code is not 0.
- R8: While seg_we or pt_we is high, req_ready is low and no request is taken. A request held across such a cycle is taken in the next free cycle. A written entry is used by every request accepted after the write.
- R9: A request accepted in cycle N produces its single response in cycle N+2. Requests may be accepted in consecutive cycles, and their responses come back in order, one per cycle.
- R10: Each segment uses its own page table through its base. The same page index in two segments with different bases gives different frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_we | input | 1 | Write strobe for a segment descriptor |
| seg_waddr | input | IDX_W (4) | Descriptor index to write |
| seg_wvalid | input | 1 | Valid flag written into the descriptor |
| seg_wlen | input | LEN_W (17) | Segment length in bytes, 0 to 65536 |
| seg_wptb | input | PTA_W (8) | Page-table base for the segment |
| seg_wperm | input | 3 | Permission flags: bit0 read, bit1 write, bit2 execute |
| pt_we | input | 1 | Write strobe for a page entry |
| pt_waddr | input | PTA_W (8) | Page entry index to write |
| pt_wvalid | input | 1 | Valid flag written into the page entry |
| pt_wframe | input | FRAME_W (14) | Frame number written into the page entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_seg | input | SEG_W (18) | Segment number |
| req_off | input | OFF_W (16) | Offset inside the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 none |
| resp_valid | output | 1 | Response present, for one cycle |
| resp_fault | output | 3 | 0 ok, 1 segment, 2 bounds, 3 permission, 4 page |
| resp_paddr | output | PA_W (24) | Physical address, 0 on a fault |

## Verification
The embedded properties watch the pipeline timing on every cycle. They check that each accepted request yields a response two cycles later and that no response appears without one. They also check that a cycle with a table write captures nothing, that an out-of-range segment number always ends in a segment fault, and that a clean response keeps the low ten offset bits unchanged. The bench scenarios are needed for what depends on table contents. These are the worked 13137 translation, the bounds edge at length−1 against length, each permission bit, page-table base wrap-around, separate per-segment page tables, fault priority when several faults apply at once, and a write that stalls a request and then takes effect.

// File: rtl/pst_pkg.sv
package pst_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_SEG    = 3'd1,
      FLT_BOUNDS = 3'd2,
      FLT_PERM   = 3'd3,
      FLT_PAGE   = 3'd4
   } pst_fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_NONE  = 2'd3
   } pst_acc_e;

   localparam int PERM_W = 3;

endpackage

// File: rtl/pst_seg_table.sv
module pst_seg_table #(
   parameter int NUM_SEGS = 16,
   parameter int LEN_W    = 17,
   parameter int PTA_W    = 8,
   localparam int IDX_W   = $clog2(NUM_SEGS)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      we,
   input  logic [IDX_W-1:0]          waddr,
   input  logic                      wvalid,
   input  logic [LEN_W-1:0]          wlen,
   input  logic [PTA_W-1:0]          wptb,
   input  logic [pst_pkg::PERM_W-1:0] wperm,
   input  logic [IDX_W-1:0]          raddr,
   output logic                      rvalid,
   output logic [LEN_W-1:0]          rlen,
   output logic [PTA_W-1:0]          rptb,
   output logic [pst_pkg::PERM_W-1:0] rperm
);

   localparam logic [IDX_W:0] ENTRY_LIM = (IDX_W+1)'(NUM_SEGS);

   logic [NUM_SEGS-1:0]               ent_valid;
   logic [LEN_W-1:0]                  ent_len  [NUM_SEGS];
   logic [PTA_W-1:0]                  ent_ptb  [NUM_SEGS];
   logic [pst_pkg::PERM_W-1:0]        ent_perm [NUM_SEGS];

   logic wr_hit;
   assign wr_hit = we && ({1'b0, waddr} < ENTRY_LIM);

   always_ff @(posedge clk) begin
      if (rst) begin
         ent_valid <= '0;
      end else if (wr_hit) begin
         ent_valid[waddr] <= wvalid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_hit) begin
         ent_len[waddr]  <= wlen;
         ent_ptb[waddr]  <= wptb;
         ent_perm[waddr] <= wperm;
      end
   end

   logic rd_in;
   assign rd_in = {1'b0, raddr} < ENTRY_LIM;

   always_comb begin
      if (rd_in) begin
         rvalid = ent_valid[raddr];
         rlen   = ent_len[raddr];
         rptb   = ent_ptb[raddr];
         rperm  = ent_perm[raddr];
      end else begin
         rvalid = 1'b0;
         rlen   = '0;
         rptb   = '0;
         rperm  = '0;
      end
   end

endmodule

// File: rtl/pst_page_table.sv
module pst_page_table #(
   parameter int PT_ENTRIES = 256,
   parameter int FRAME_W    = 14,
   localparam int PTA_W     = $clog2(PT_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               we,
   input  logic [PTA_W-1:0]   waddr,
   input  logic               wvalid,
   input  logic [FRAME_W-1:0] wframe,
   input  logic [PTA_W-1:0]   raddr,
   output logic               rvalid,
   output logic [FRAME_W-1:0] rframe
);

   localparam logic [PTA_W:0] ENTRY_LIM = (PTA_W+1)'(PT_ENTRIES);

   logic [PT_ENTRIES-1:0] pte_valid;
   logic [FRAME_W-1:0]    pte_frame [PT_ENTRIES];

   logic wr_hit;
   assign wr_hit = we && ({1'b0, waddr} < ENTRY_LIM);

   always_ff @(posedge clk) begin
      if (rst) begin
         pte_valid <= '0;
      end else if (wr_hit) begin
         pte_valid[waddr] <= wvalid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_hit) begin
         pte_frame[waddr] <= wframe;
      end
   end

   logic rd_in;
   assign rd_in  = {1'b0, raddr} < ENTRY_LIM;
   assign rvalid = rd_in ? pte_valid[raddr] : 1'b0;
   assign rframe = rd_in ? pte_frame[raddr] : '0;

endmodule

// File: rtl/pst_seg_check.sv
module pst_seg_check #(
   parameter int OFF_W = 16,
   localparam int LEN_W = OFF_W + 1
) (
   input  logic                        seg_ok,
   input  logic [OFF_W-1:0]            off,
   input  logic [LEN_W-1:0]            len,
   input  logic [pst_pkg::PERM_W-1:0]  perm,
   input  pst_pkg::pst_acc_e           acc,
   output pst_pkg::pst_fault_e         fault
);
   import pst_pkg::*;

   logic over_len;
   logic allowed;

   assign over_len = {1'b0, off} >= len;

   always_comb begin
      unique case (acc)
         ACC_READ:  allowed = perm[0];
         ACC_WRITE: allowed = perm[1];
         ACC_EXEC:  allowed = perm[2];
         default:   allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (!seg_ok)        fault = FLT_SEG;
      else if (over_len)  fault = FLT_BOUNDS;
      else if (!allowed)  fault = FLT_PERM;
      else                fault = FLT_NONE;
   end

endmodule

// File: rtl/pst_translator.sv
module pst_translator #(
   parameter int SEG_W      = 18,
   parameter int OFF_W      = 16,
   parameter int PAGE_OFF_W = 10,
   parameter int NUM_SEGS   = 16,
   parameter int PT_ENTRIES = 256,
   parameter int FRAME_W    = 14,
   localparam int IDX_W     = $clog2(NUM_SEGS),
   localparam int PTA_W     = $clog2(PT_ENTRIES),
   localparam int LEN_W     = OFF_W + 1,
   localparam int PIDX_W    = OFF_W - PAGE_OFF_W,
   localparam int PA_W      = FRAME_W + PAGE_OFF_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               seg_we,
   input  logic [IDX_W-1:0]   seg_waddr,
   input  logic               seg_wvalid,
   input  logic [LEN_W-1:0]   seg_wlen,
   input  logic [PTA_W-1:0]   seg_wptb,
   input  logic [2:0]         seg_wperm,
   input  logic               pt_we,
   input  logic [PTA_W-1:0]   pt_waddr,
   input  logic               pt_wvalid,
   input  logic [FRAME_W-1:0] pt_wframe,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_acc,
   output logic               resp_valid,
   output logic [2:0]         resp_fault,
   output logic [PA_W-1:0]    resp_paddr
);
   import pst_pkg::*;

   // ---------------- elaboration-time parameter checks ----------------
   if (OFF_W <= PAGE_OFF_W) begin : g_bad_split
      $error("pst_translator: OFF_W must exceed PAGE_OFF_W");
   end
   if (NUM_SEGS < 2 || NUM_SEGS > (1 << SEG_W)) begin : g_bad_nseg
      $error("pst_translator: NUM_SEGS out of range");
   end
   if (PT_ENTRIES < 2 || FRAME_W < 1) begin : g_bad_pt
      $error("pst_translator: page table shape invalid");
   end

   // ---------------- request acceptance ----------------
   logic cfg_busy;
   logic accept;
   assign cfg_busy  = seg_we || pt_we;
   assign req_ready = !rst && !cfg_busy;
   assign accept    = req_valid && req_ready;

   // segment-number range: a full-size table needs no compare
   logic seg_in_range;
   if (NUM_SEGS == (1 << SEG_W)) begin : g_full_space
      assign seg_in_range = 1'b1;
   end else begin : g_part_space
      localparam logic [SEG_W:0] SEG_LIM = (SEG_W+1)'(NUM_SEGS);
      assign seg_in_range = {1'b0, req_seg} < SEG_LIM;
   end

   // ---------------- segment table ----------------
   logic               st_valid;
   logic [LEN_W-1:0]   st_len;
   logic [PTA_W-1:0]   st_ptb;
   logic [2:0]         st_perm;

   pst_seg_table #(
      .NUM_SEGS (NUM_SEGS),
      .LEN_W    (LEN_W),
      .PTA_W    (PTA_W)
   ) u_seg_table (
      .clk    (clk),
      .rst    (rst),
      .we     (seg_we),
      .waddr  (seg_waddr),
      .wvalid (seg_wvalid),
      .wlen   (seg_wlen),
      .wptb   (seg_wptb),
      .wperm  (seg_wperm),
      .raddr  (req_seg[IDX_W-1:0]),
      .rvalid (st_valid),
      .rlen   (st_len),
      .rptb   (st_ptb),
      .rperm  (st_perm)
   );

   // ---------------- stage 1: descriptor captured ----------------
   logic               s1_valid;
   logic               s1_seg_ok;
   logic [OFF_W-1:0]   s1_off;
   logic [LEN_W-1:0]   s1_len;
   logic [PTA_W-1:0]   s1_ptb;
   logic [2:0]         s1_perm;
   pst_acc_e           s1_acc;

   always_ff @(posedge clk) begin
      if (rst) s1_valid <= 1'b0;
      else     s1_valid <= accept;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         s1_seg_ok <= seg_in_range && st_valid;
         s1_off    <= req_off;
         s1_len    <= st_len;
         s1_ptb    <= st_ptb;
         s1_perm   <= st_perm;
         s1_acc    <= pst_acc_e'(req_acc);
      end
   end

   // ---------------- descriptor checks ----------------
   pst_fault_e s1_fault;

   pst_seg_check #(
      .OFF_W (OFF_W)
   ) u_seg_check (
      .seg_ok (s1_seg_ok),
      .off    (s1_off),
      .len    (s1_len),
      .perm   (s1_perm),
      .acc    (s1_acc),
      .fault  (s1_fault)
   );

   // ---------------- page table ----------------
   logic [PIDX_W-1:0]  s1_pidx;
   logic [PTA_W-1:0]   pt_raddr;
   logic               pt_rvalid;
   logic [FRAME_W-1:0] pt_rframe;

   assign s1_pidx  = s1_off[OFF_W-1 -: PIDX_W];
   assign pt_raddr = s1_ptb + PTA_W'(s1_pidx);

   pst_page_table #(
      .PT_ENTRIES (PT_ENTRIES),
      .FRAME_W    (FRAME_W)
   ) u_page_table (
      .clk    (clk),
      .rst    (rst),
      .we     (pt_we),
      .waddr  (pt_waddr),
      .wvalid (pt_wvalid),
      .wframe (pt_wframe),
      .raddr  (pt_raddr),
      .rvalid (pt_rvalid),
      .rframe (pt_rframe)
   );

   // ---------------- stage 2: page entry captured ----------------
   logic                  s2_valid;
   pst_fault_e            s2_fault;
   logic                  s2_pte_ok;
   logic [FRAME_W-1:0]    s2_frame;
   logic [PAGE_OFF_W-1:0] s2_inpage;

   always_ff @(posedge clk) begin
      if (rst) s2_valid <= 1'b0;
      else     s2_valid <= s1_valid;
   end

   always_ff @(posedge clk) begin
      if (s1_valid) begin
         s2_fault  <= s1_fault;
         s2_pte_ok <= pt_rvalid;
         s2_frame  <= pt_rframe;
         s2_inpage <= s1_off[PAGE_OFF_W-1:0];
      end
   end

   pst_fault_e fin_fault;
   always_comb begin
      if (s2_fault != FLT_NONE) fin_fault = s2_fault;
      else if (!s2_pte_ok)      fin_fault = FLT_PAGE;
      else                      fin_fault = FLT_NONE;
   end

   assign resp_valid = s2_valid;
   assign resp_fault = fin_fault;
   assign resp_paddr = (fin_fault == FLT_NONE) ? {s2_frame, s2_inpage} : '0;

   // ---------------- assertions ----------------
   a_r9_latency: assert property (@(posedge clk) disable iff (rst)
      $past(req_valid && req_ready, 2) |-> resp_valid)
      else $error("R9: accepted request gave no response two cycles later");

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !$past(req_valid && req_ready, 2) |-> !resp_valid)
      else $error("R9: response without a matching request");

   a_r8_no_capture_on_write: assert property (@(posedge clk) disable iff (rst)
      (seg_we || pt_we) |=> !s1_valid)
      else $error("R8: request captured during a table write");

   a_r3_range_fault: assert property (@(posedge clk) disable iff (rst)
      $past(req_valid && req_ready && !seg_in_range, 2) |-> (resp_fault == FLT_SEG))
      else $error("R3: out-of-range segment not reported");

   a_r2_inpage_kept: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_fault == FLT_NONE)
         |-> (resp_paddr[PAGE_OFF_W-1:0] == $past(req_off[PAGE_OFF_W-1:0], 2)))
      else $error("R2: in-page offset altered");

endmodule

// File: tb/tb_pst_translator.sv
module tb_pst_translator;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        seg_we = 1'b0;
   logic [3:0]  seg_waddr = '0;
   logic        seg_wvalid = 1'b0;
   logic [16:0] seg_wlen = '0;
   logic [7:0]  seg_wptb = '0;
   logic [2:0]  seg_wperm = '0;
   logic        pt_we = 1'b0;
   logic [7:0]  pt_waddr = '0;
   logic        pt_wvalid = 1'b0;
   logic [13:0] pt_wframe = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [17:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic [1:0]  req_acc = '0;
   logic        resp_valid;
   logic [2:0]  resp_fault;
   logic [23:0] resp_paddr;

   always #2 clk = ~clk;   // 250 MHz

   pst_translator dut (
      .clk(clk), .rst(rst),
      .seg_we(seg_we), .seg_waddr(seg_waddr), .seg_wvalid(seg_wvalid),
      .seg_wlen(seg_wlen), .seg_wptb(seg_wptb), .seg_wperm(seg_wperm),
      .pt_we(pt_we), .pt_waddr(pt_waddr), .pt_wvalid(pt_wvalid), .pt_wframe(pt_wframe),
      .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
      .req_off(req_off), .req_acc(req_acc),
      .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
   );

   typedef struct {
      int     fault;
      longint paddr;
      int     stamp;
      string  tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: pushes the expected response once the request is taken
   task automatic send(input int seg, input int off, input int acc,
                       input int ef, input longint epa, input string tag);
      bit rdy;
      do begin
         @(negedge clk);
         req_valid = 1'b1;
         req_seg   = 18'(seg);
         req_off   = 16'(off);
         req_acc   = 2'(acc);
         rdy       = req_ready;
         @(posedge clk);
      end while (!rdy);
      #1;
      req_valid = 1'b0;
      q.push_back('{ef, epa, cyc, tag});
   endtask

   task automatic wr_seg(input int idx, input int len, input int ptb, input int perm, input bit v);
      @(negedge clk);
      seg_we = 1'b1; seg_waddr = 4'(idx); seg_wlen = 17'(len);
      seg_wptb = 8'(ptb); seg_wperm = 3'(perm); seg_wvalid = v;
      @(posedge clk); #1;
      seg_we = 1'b0;
   endtask

   task automatic wr_pt(input int idx, input int frame, input bit v);
      @(negedge clk);
      pt_we = 1'b1; pt_waddr = 8'(idx); pt_wframe = 14'(frame); pt_wvalid = v;
      @(posedge clk); #1;
      pt_we = 1'b0;
   endtask

   task automatic drain();
      repeat (4) @(negedge clk);
   endtask

   // monitor: pops and compares each response
   always @(negedge clk) begin
      if (!rst && resp_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R9 unexpected response", resp_fault, -1);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(resp_fault == 3'(e.fault), {e.tag, " fault"}, resp_fault, e.fault);
            chk(resp_paddr == 24'(e.paddr), {e.tag, " paddr"}, resp_paddr, e.paddr);
            chk(cyc == e.stamp + 1, "R9 latency", cyc - e.stamp, 1);
         end
      end
   end

   initial begin
      repeat (10000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=0", q.size());
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(resp_valid == 1'b0, "R1 resp_valid in reset", resp_valid, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(resp_valid == 1'b0, "R1 idle after reset", resp_valid, 0);
      send(0, 0, 0, 1, 0, "R1 empty table");
      send(15, 3921, 0, 1, 0, "R1 seg15 unset");
      drain();

      // seg 15: len 5096, base 32, read only; page 3 -> frame 12, page 4 -> frame 100
      wr_seg(15, 5096, 32, 3'b001, 1'b1);
      wr_pt(35, 12, 1'b1);
      wr_pt(36, 100, 1'b1);
      send(15, 3921, 0, 0, 13137, "R2 worked example");
      send(15, 5095, 0, 0, 103399, "R4 length-1 passes");
      send(15, 5096, 0, 2, 0, "R4 offset equals length");
      send(16, 0, 0, 1, 0, "R3 seg at limit");
      send(1 << 17, 0, 0, 1, 0, "R3 high seg");
      send(4, 0, 0, 1, 0, "R3 invalid descriptor");
      send(15, 3921, 1, 3, 0, "R5 write refused");
      send(15, 3921, 2, 3, 0, "R5 exec refused");
      send(15, 3921, 3, 3, 0, "R5 code3 refused");
      send(15, 100, 0, 4, 0, "R6 invalid page");
      send(15, 6000, 1, 2, 0, "R7 bounds over perm");
      send(15, 100, 1, 3, 0, "R7 perm over page");
      drain();

      // seg 3: full length, base 200, rwx; page 3 -> 0x3FFF, wrap index 7 -> frame 5
      wr_seg(3, 65536, 200, 3'b111, 1'b1);
      wr_pt(203, 16383, 1'b1);
      send(3, 3077, 2, 0, 16776197, "R10 own page table");
      send(3, 65535, 1, 4, 0, "R6 wrapped entry invalid");
      drain();
      wr_pt(7, 5, 1'b1);
      send(3, 65535, 1, 0, 6143, "R6 base wrap");
      send(3, 65535, 0, 0, 6143, "R4 full-length segment");

      // write stalls a pending request
      @(negedge clk);
      pt_we = 1'b1; pt_waddr = 8'd50; pt_wframe = 14'd9; pt_wvalid = 1'b1;
      req_valid = 1'b1; req_seg = 18'd15; req_off = 16'd3921; req_acc = 2'd0;
      #1;
      chk(req_ready == 1'b0, "R8 ready low on write", req_ready, 0);
      @(posedge clk); #1;
      pt_we = 1'b0;
      send(15, 3921, 0, 0, 13137, "R8 request after stall");
      drain();

      // back-to-back pipelining
      send(15, 3921, 0, 0, 13137, "R9 burst a");
      send(3, 3077, 2, 0, 16776197, "R9 burst b");
      send(15, 5096, 0, 2, 0, "R9 burst c");
      drain();

      // rewrite takes effect
      wr_seg(15, 5096, 32, 3'b001, 1'b0);
      send(15, 3921, 0, 1, 0, "R8 invalidated descriptor");
      wr_seg(15, 5096, 32, 3'b011, 1'b1);
      send(15, 3921, 1, 0, 13137, "R8 new permission used");
      drain();

      chk(q.size() == 0, "R9 all responses seen", q.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule